// File: doc/BRIEF.md
# Staged Power-Switch Sequencer

This block drives the 8-bit control word of a supply clamp that feeds one processor core. Opening the clamp all at once would draw a large inrush current, so an open request walks the word through a fixed series of codes. Each code leaves one more group of switch segments conducting than the code before it, and each one is held for a dwell time. A close request returns the word to the fully closed code in a single write and then holds it for the same dwell time. A code of 0x00 means the clamp is fully conducting and the core is powered. A code of 0xFF means it is fully off.

A requester presents a one-cycle request together with a direction bit and the current readback of the switch word. The block reports `busy` while a sequence runs and gives a one-cycle `done` pulse when the sequence finishes. An open request that finds the readback already at 0x00 writes nothing and completes at once. The dwell is measured in clock cycles, taken as the product of a cycles-per-microsecond parameter and a dwell-in-microseconds parameter (default 10 µs). The dwell counter starts again from zero each time the code changes.

Top module: `pwr_ramp_seq`

## Requirements
- R1: While `rst` is high and after it falls, `sw_word` is 0xFF, `busy` is 0 and `done` is 0, until the first request is accepted.
- R2: An accepted open request (`req_open`=1) drives `sw_word` to 0xFF, then 0xFE, then 0xF8, then 0xF0, then 0x00. The first code appears in the cycle after the request edge, and no other value appears in between.
- R3: Each code of a sequence is held for exactly DWELL = CYC_PER_US*DWELL_US clock cycles before the next code, or before completion.
- R4: An open request seen while idle with `sw_cur` equal to 0x00 leaves `sw_word` unchanged and keeps `busy` at 0. It raises `done` in the very next cycle.
- R5: An accepted close request (`req_open`=0) writes 0xFF and holds `busy` high for DWELL cycles before completing.
- R6: `busy` is 1 for the whole of a sequence. A request (`req_valid`=1) seen while `busy` is 1 is ignored: the code order and the timing are unchanged.
- R7: `done` is high for exactly one cycle. For a real sequence that cycle directly follows the last dwell, and `busy` falls on the same edge that raises `done`.
- R8: A close request is never skipped. Even with `sw_cur` already 0xFF it runs the full dwell before `done`.
- R9: An open request is skipped only when `sw_cur` is exactly 0x00. Any other readback, such as a partly open 0xF0, starts the full sequence from 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_open | input | 1 | Direction: 1 opens (powers) the clamp, 0 closes it |
| sw_cur | input | 8 | Current readback of the switch word |
| sw_word | output | 8 | Registered switch control word |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the code boundaries: a dwell counter that is off by one shifts every code edge by a cycle, and the samples taken in every cycle catch that. It issues open requests against a readback of exactly 0x00 and also against partly open values such as 0xF0 and 0xFE. A wrong skip test would either rewrite a powered clamp or leave a half-open one in place. It sends stray requests into the middle of a sequence, which a design that accepts them would restart or reverse. It also closes an already closed clamp, which a design that skips closes would complete with no dwell.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;

    localparam int CODE_W     = 8;
    localparam int OPEN_STEPS = 5;
    localparam int IDX_W      = $clog2(OPEN_STEPS);
    localparam int SLOTS      = 2 ** IDX_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam code_t CODE_SHUT = 8'hFF;
    localparam code_t CODE_FULL = 8'h00;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_t;

    typedef struct packed {
        logic open;
        idx_t idx;
    } step_t;

    // Switch word for position idx of the opening ramp.
    function automatic code_t open_code(input idx_t idx);
        case (idx)
            idx_t'(0): open_code = 8'hFF;
            idx_t'(1): open_code = 8'hFE;
            idx_t'(2): open_code = 8'hF8;
            idx_t'(3): open_code = 8'hF0;
            default:   open_code = CODE_FULL;
        endcase
    endfunction

    // True when the given step is the final one of its direction.
    function automatic logic is_last(input step_t s);
        if (s.open) is_last = (s.idx == idx_t'(OPEN_STEPS - 1));
        else        is_last = 1'b1;
    endfunction

endpackage

// File: rtl/pwr_ramp_dwell.sv
module pwr_ramp_dwell #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && (cnt_q == CNT_END);

    always_ff @(posedge clk) begin
        if (rst || restart || expire) cnt_q <= '0;
        else if (run)                 cnt_q <= cnt_q + 1'b1;
    end

    // R3
    dwell_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && !expire) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pwr_ramp_steps.sv
module pwr_ramp_steps
    import pwr_ramp_pkg::*;
(
    input  step_t step,
    output code_t code
);
    code_t ramp_tab [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < OPEN_STEPS) begin : g_used
            assign ramp_tab[g] = open_code(idx_t'(g));
        end else begin : g_pad
            assign ramp_tab[g] = CODE_FULL;
        end
    end

    assign code = step.open ? ramp_tab[step.idx] : CODE_SHUT;

endmodule

// File: rtl/pwr_ramp_fsm.sv
module pwr_ramp_fsm
    import pwr_ramp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  logic  req_open,
    input  code_t sw_cur,
    input  logic  expire,
    input  code_t code_nxt,
    output step_t step_d,
    output logic  restart,
    output logic  run,
    output code_t sw_word,
    output logic  busy,
    output logic  done
);
    state_t state_q, state_d;
    step_t  step_q;
    code_t  sw_q;
    logic   done_q, done_d;

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        restart = 1'b0;
        done_d  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_open && (sw_cur == CODE_FULL)) begin
                        done_d = 1'b1;
                    end else begin
                        step_d  = '{open: req_open, idx: '0};
                        state_d = ST_RUN;
                        restart = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (expire) begin
                    if (is_last(step_q)) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        step_d.idx = step_q.idx + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            sw_q    <= CODE_SHUT;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            done_q  <= done_d;
            if (state_d == ST_RUN) sw_q <= code_nxt;
        end
    end

    assign run     = (state_q == ST_RUN);
    assign busy    = run;
    assign done    = done_q;
    assign sw_word = sw_q;

    // R2
    ramp_order_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sw_q) |-> (sw_q == CODE_SHUT || sw_q < $past(sw_q)));

    // R4
    skip_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_open && sw_cur == CODE_FULL)
            |=> (done && !busy && $stable(sw_q)));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !expire) |=> busy);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
    import pwr_ramp_pkg::*;
#(
    parameter int CYC_PER_US = 200,
    parameter int DWELL_US   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_open,
    input  logic [7:0] sw_cur,
    output logic [7:0] sw_word,
    output logic       busy,
    output logic       done
);
    localparam int DWELL = CYC_PER_US * DWELL_US;

    step_t step_d;
    code_t code_nxt;
    logic  restart, run, expire;

    pwr_ramp_steps u_steps (
        .step (step_d),
        .code (code_nxt)
    );

    pwr_ramp_dwell #(.LIMIT(DWELL)) u_dwell (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (run),
        .expire  (expire)
    );

    pwr_ramp_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_open  (req_open),
        .sw_cur    (sw_cur),
        .expire    (expire),
        .code_nxt  (code_nxt),
        .step_d    (step_d),
        .restart   (restart),
        .run       (run),
        .sw_word   (sw_word),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: tb/pwr_ramp_seq_bench.sv
module pwr_ramp_seq_bench;

    localparam int CPU = 3;
    localparam int DUS = 10;
    localparam int D   = CPU * DUS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_open = 1'b0;
    logic       fb_en = 1'b1;
    logic [7:0] force_cur = 8'h00;
    logic [7:0] sw_cur;
    logic [7:0] sw_word;
    logic       busy, done;

    int checks = 0;
    int errors = 0;

    assign sw_cur = fb_en ? sw_word : force_cur;

    always #2.5 clk = ~clk;

    pwr_ramp_seq #(.CYC_PER_US(CPU), .DWELL_US(DUS)) u_pwr_ramp_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_open(req_open),
        .sw_cur(sw_cur), .sw_word(sw_word), .busy(busy), .done(done)
    );

    function automatic logic [7:0] exp_code(input bit open, input int i);
        if (!open) return 8'hFF;
        case (i)
            0: return 8'hFF;
            1: return 8'hFE;
            2: return 8'hF8;
            3: return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Issue one request at a negedge and follow it to completion.
    task automatic run_req(input bit open, input bit use_fb, input logic [7:0] cur, input int inject);
        bit         skip;
        int         n;
        logic [7:0] prev;
        fb_en     = use_fb;
        force_cur = cur;
        #0;
        prev = sw_word;
        skip = open && (sw_cur == 8'h00);
        req_valid = 1'b1;
        req_open  = open;
        @(negedge clk);
        req_valid = 1'b0;
        if (skip) begin
            chk(done == 1'b1, "R4 done after skip", done, 1);
            chk(busy == 1'b0, "R4 busy after skip", busy, 0);
            chk(sw_word == prev, "R4 word unchanged", sw_word, prev);
            @(negedge clk);
            chk(done == 1'b0, "R7 skip done width", done, 0);
            return;
        end
        n = open ? 5 : 1;
        for (int s = 0; s < n * D; s++) begin
            chk(sw_word == exp_code(open, s / D),
                open ? "R2/R3 open code" : "R5 close code", sw_word, exp_code(open, s / D));
            chk(busy == 1'b1, "R6 busy during sequence", busy, 1);
            chk(done == 1'b0, "R7 no early done", done, 0);
            if (s == inject) begin
                req_valid = 1'b1;
                req_open  = $urandom % 2;
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(done == 1'b1, "R7 done after last dwell", done, 1);
        chk(busy == 1'b0, "R7 busy falls with done", busy, 0);
        chk(sw_word == exp_code(open, n - 1), "R2 final code", sw_word, exp_code(open, n - 1));
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(busy == 1'b0, "R6 idle after sequence", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(sw_word == 8'hFF, "R1 reset word", sw_word, 8'hFF);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sw_word == 8'hFF && !busy && !done, "R1 after reset", sw_word, 8'hFF);

        // R8: close from closed still dwells
        run_req(1'b0, 1'b1, 8'h00, -1);
        // R2: full open with loopback readback
        run_req(1'b1, 1'b1, 8'h00, -1);
        // R4: open when already open is skipped
        run_req(1'b1, 1'b1, 8'h00, -1);
        // R9: partial readback forces full sequence
        run_req(1'b1, 1'b0, 8'hF0, -1);
        run_req(1'b1, 1'b0, 8'hFE, 7);
        // R6: stray request mid sequence, then R5 close
        run_req(1'b0, 1'b1, 8'h00, 10);
        run_req(1'b1, 1'b1, 8'h00, D);

        for (int it = 0; it < 24; it++) begin
            bit         open, use_fb;
            logic [7:0] cur;
            int         inj;
            open   = ($urandom % 2) == 1;
            use_fb = ($urandom % 4) != 0;
            case ($urandom % 5)
                0: cur = 8'h00;
                1: cur = 8'hFF;
                2: cur = 8'hF0;
                3: cur = 8'hF8;
                default: cur = 8'($urandom);
            endcase
            inj = (($urandom % 3) == 0) ? int'($urandom % ((open ? 5 : 1) * D)) : -1;
            run_req(open, use_fb, cur, inj);
            repeat ($urandom % 3) @(negedge clk);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule